// File: doc/BRIEF.md
# Dual-Channel Input Capture Timer

This block timestamps events on two external pins. A 16-bit counter runs freely on the system clock divided by a prescaler. When a pin makes its selected transition, the current counter value is copied into that pin's capture register and the channel's flag is raised. An interrupt line combines the flags with two enable bits.

Software uses an 8-bit register port with a 3-bit address and one-cycle read and write strobes. Reads are combinational, and their side effects take hold at the clock edge where the strobe is high. Each capture value is read as two bytes. Reading the upper byte locks the register, so the pair stays consistent until the lower byte is accessed.

A flag clears only after two steps in order. First software reads the status register while the flag is set. Then it reads or writes that channel's lower capture byte.

Top module: `tcap_dual`

## Requirements
- R1: After synchronous reset, every readable register returns 0 and `irq` is low. The counter and prescaler start from 0.
- R2: Bit 0 of address 0 picks the active edge of pin 0, and bit 0 of address 1 picks the active edge of pin 1. A value of 1 selects a rising edge and 0 selects a falling edge. The opposite transition neither captures nor sets a flag.
- R3: A pin change applied between clock edges is captured at the third rising clock edge that follows. The capture register takes the counter value present just before that edge, and the channel flag is set at the same edge.
- R4: Bits [2:1] of address 1 choose the prescale ratio: 00 divides by 4, 01 by 2, 10 by 8, and 11 by 8. The counter advances by exactly one each time the prescaler completes a period.
- R5: `irq` is high exactly while bit 1 of address 0 (capture interrupt enable) is set, bit 2 of address 0 (global enable) is set, and at least one flag is set. A flag raised while the enables are off keeps the request pending.
- R6: Address 2 is a read-only status register with flag 0 at bit 7 and flag 1 at bit 4. A flag clears at the edge of a read or write of its channel's lower byte, but only if a status read has already been made while that flag was set. A status read made while a flag is clear does not arm that flag's clear.
- R7: A read of a channel's upper byte (address 4 for channel 0, address 6 for channel 1) locks the capture register. While it is locked, an active edge sets the flag but its value is dropped. The lock ends on a read or write of the lower byte (address 5 or 7).
- R8: When the register is unlocked, each new active edge overwrites the capture register, so it always holds the most recent capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 2 | Asynchronous capture pins, bit n for channel n |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| irq | output | 1 | Capture interrupt request |

## Verification
If the lock or the clear-arm bit sits in the wrong state, the fault shows on the next access to the lower byte. The byte pair then comes back torn, or the status bit stays set or drops one sequence early. A prescaler fault gives capture values that drift away from an independently counted model, and the gap widens with every capture, so even the first timestamp after a ratio change exposes it. Edge-polarity or synchroniser-depth faults move the capture by at least one clock, or suppress it, and the status read that follows shows this within four cycles.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    localparam int CNT_W   = 16;
    localparam int PS_W    = 3;
    localparam int SYNC_N  = 2;
    localparam int NCH     = 2;

    typedef enum logic [2:0] {
        RA_CTL0  = 3'd0,
        RA_CTL1  = 3'd1,
        RA_STAT  = 3'd2,
        RA_RSV   = 3'd3,
        RA_C0_HI = 3'd4,
        RA_C0_LO = 3'd5,
        RA_C1_HI = 3'd6,
        RA_C1_LO = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic glob_en;
        logic cap_ie;
        logic rise0;
    } ctl0_t;

    typedef struct packed {
        logic [1:0] ps_sel;
        logic       rise1;
    } ctl1_t;

    function automatic logic [PS_W:0] ps_ratio(input logic [1:0] sel);
        case (sel)
            2'b00:   return (PS_W+1)'(4);
            2'b01:   return (PS_W+1)'(2);
            default: return (PS_W+1)'(8);
        endcase
    endfunction

endpackage

// File: rtl/tcap_sync_edge.sv
module tcap_sync_edge
    import tcap_pkg::*;
#(
    parameter int STAGES = SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise_sel,
    output logic hit
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign cur = chain_q[STAGES-1];
    assign hit = rise_sel ? (cur & ~prev_q) : (~cur & prev_q);
endmodule

// File: rtl/tcap_prescaler.sv
module tcap_prescaler
    import tcap_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    sel,
    output logic          tick,
    output logic [CW-1:0] count
);
    logic [PS_W-1:0] pc_q;
    logic [PS_W:0]   last;

    assign last = ps_ratio(sel) - (PS_W+1)'(1);
    assign tick = ({1'b0, pc_q} >= last);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            count <= '0;
        end else if (tick) begin
            pc_q  <= '0;
            count <= count + CW'(1);
        end else begin
            pc_q  <= pc_q + PS_W'(1);
        end
    end
endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
    import tcap_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  logic [CW-1:0] count,
    input  logic          hi_rd,
    input  logic          lo_acc,
    input  logic          stat_rd,
    output logic [CW-1:0] cap,
    output logic          flag,
    output logic          locked
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap     <= '0;
            flag    <= 1'b0;
            locked  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (hit && !locked)
                cap <= count;

            if (lo_acc)
                locked <= 1'b0;
            else if (hi_rd)
                locked <= 1'b1;

            if (hit)
                flag <= 1'b1;
            else if (lo_acc && armed_q)
                flag <= 1'b0;

            if (lo_acc)
                armed_q <= 1'b0;
            else if (stat_rd && flag)
                armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/tcap_dual.sv
module tcap_dual
    import tcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cap_pin,
    input  logic [2:0] bus_addr,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    ctl0_t                     ctl0_q;
    ctl1_t                     ctl1_q;
    reg_addr_e                 ra;
    logic [NCH-1:0]            edge_sel;
    logic [NCH-1:0]            hit_v;
    logic [NCH-1:0]            hi_rd_v;
    logic [NCH-1:0]            lo_acc_v;
    logic [NCH-1:0]            flag_v;
    logic [NCH-1:0]            locked_v;
    logic [NCH-1:0][CNT_W-1:0] cap_v;
    logic [CNT_W-1:0]          cnt_val;
    logic                      cnt_tick;
    logic                      stat_rd;
    logic                      unused_wbits;

    assign ra           = reg_addr_e'(bus_addr);
    assign unused_wbits = ^bus_wdata[7:3];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl0_q <= '0;
            ctl1_q <= '0;
        end else if (bus_wr) begin
            if (ra == RA_CTL0) ctl0_q <= ctl0_t'(bus_wdata[2:0]);
            if (ra == RA_CTL1) ctl1_q <= ctl1_t'(bus_wdata[2:0]);
        end
    end

    assign edge_sel = {ctl1_q.rise1, ctl0_q.rise0};
    assign stat_rd  = bus_rd && (ra == RA_STAT);
    assign hi_rd_v  = {bus_rd && (ra == RA_C1_HI), bus_rd && (ra == RA_C0_HI)};
    assign lo_acc_v = {(bus_rd || bus_wr) && (ra == RA_C1_LO),
                       (bus_rd || bus_wr) && (ra == RA_C0_LO)};

    tcap_prescaler #(.CW(CNT_W)) u_ps (
        .clk   (clk),
        .rst   (rst),
        .sel   (ctl1_q.ps_sel),
        .tick  (cnt_tick),
        .count (cnt_val)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tcap_sync_edge #(.STAGES(SYNC_N)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .pin      (cap_pin[g]),
            .rise_sel (edge_sel[g]),
            .hit      (hit_v[g])
        );
        tcap_channel #(.CW(CNT_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .hit     (hit_v[g]),
            .count   (cnt_val),
            .hi_rd   (hi_rd_v[g]),
            .lo_acc  (lo_acc_v[g]),
            .stat_rd (stat_rd),
            .cap     (cap_v[g]),
            .flag    (flag_v[g]),
            .locked  (locked_v[g])
        );
    end

    always_comb begin
        case (ra)
            RA_CTL0:  bus_rdata = {5'b0, ctl0_q};
            RA_CTL1:  bus_rdata = {5'b0, ctl1_q};
            RA_STAT:  bus_rdata = {flag_v[0], 2'b00, flag_v[1], 4'b0000};
            RA_C0_HI: bus_rdata = cap_v[0][15:8];
            RA_C0_LO: bus_rdata = cap_v[0][7:0];
            RA_C1_HI: bus_rdata = cap_v[1][15:8];
            RA_C1_LO: bus_rdata = cap_v[1][7:0];
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign irq = ctl0_q.cap_ie & ctl0_q.glob_en & (|flag_v);
endmodule

// File: rtl/tcap_dual_chk.sv
module tcap_dual_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  hit,
    input logic [1:0]  lo_acc,
    input logic [1:0]  locked,
    input logic [1:0]  flag,
    input logic [15:0] cap0,
    input logic [15:0] cap1,
    input logic [15:0] count,
    input logic        tick,
    input logic        ie,
    input logic        ge,
    input logic        irq
);
    a_r3_cap_ch0: assert property (@(posedge clk) disable iff (rst)
        (hit[0] && !locked[0]) |=> cap0 == $past(count));
    a_r3_cap_ch1: assert property (@(posedge clk) disable iff (rst)
        (hit[1] && !locked[1]) |=> cap1 == $past(count));
    a_r3_flag_ch0: assert property (@(posedge clk) disable iff (rst)
        hit[0] |=> flag[0]);
    a_r3_flag_ch1: assert property (@(posedge clk) disable iff (rst)
        hit[1] |=> flag[1]);
    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        tick |=> count == $past(count) + 16'd1);
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));
    a_r5_raise: assert property (@(posedge clk) disable iff (rst)
        (ie && ge && (flag != 2'b00)) |-> irq);
    a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
        (!ie || !ge) |-> !irq);
    a_r6_clr_ch0: assert property (@(posedge clk) disable iff (rst)
        $fell(flag[0]) |-> $past(lo_acc[0]));
    a_r6_clr_ch1: assert property (@(posedge clk) disable iff (rst)
        $fell(flag[1]) |-> $past(lo_acc[1]));
    a_r7_lock_ch0: assert property (@(posedge clk) disable iff (rst)
        locked[0] |=> $stable(cap0));
    a_r7_lock_ch1: assert property (@(posedge clk) disable iff (rst)
        locked[1] |=> $stable(cap1));
endmodule

bind tcap_dual tcap_dual_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .hit    (hit_v),
    .lo_acc (lo_acc_v),
    .locked (locked_v),
    .flag   (flag_v),
    .cap0   (cap_v[0]),
    .cap1   (cap_v[1]),
    .count  (cnt_val),
    .tick   (cnt_tick),
    .ie     (ctl0_q.cap_ie),
    .ge     (ctl0_q.glob_en),
    .irq    (irq)
);

// File: tb/sim_tcap_dual.sv
module sim_tcap_dual;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cap_pin = 2'b00;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    tcap_dual u0 (
        .clk(clk), .rst(rst), .cap_pin(cap_pin), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // independent timebase model built from R4
    logic [2:0]  m_pc;
    logic [15:0] m_cnt, m_prev;
    logic [1:0]  m_sel;

    function automatic int ratio(input logic [1:0] s);
        if (s == 2'b00) return 4;
        if (s == 2'b01) return 2;
        return 8;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pc <= 0; m_cnt <= 0; m_prev <= 0; m_sel <= 0;
        end else begin
            m_prev <= m_cnt;
            if (int'(m_pc) >= ratio(m_sel) - 1) begin
                m_pc  <= 0;
                m_cnt <= m_cnt + 16'd1;
            end else begin
                m_pc <= m_pc + 3'd1;
            end
            if (bus_wr && bus_addr == 3'd1) m_sel <= bus_wdata[2:1];
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // drive a pin level, return counter value just before the third edge
    task automatic pin(input int ch, input logic v, output logic [15:0] exp);
        cap_pin[ch] = v;
        repeat (3) @(posedge clk);
        #1 exp = m_prev;
        @(negedge clk);
    endtask

    task automatic read_cap(input int ch, output logic [15:0] val);
        logic [7:0] h, l;
        rd(ch == 0 ? 3'd4 : 3'd6, h);
        rd(ch == 0 ? 3'd5 : 3'd7, l);
        val = {h, l};
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reg after reset", {8'h0, d}, 16'h0);
        end
        check("R1 irq after reset", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_rise_ch0();
        logic [15:0] e, v; logic [7:0] s;
        wr(3'd1, 8'h02);               // ratio 2, ch1 falling
        wr(3'd0, 8'h01);               // ch0 rising
        repeat (7) @(negedge clk);
        pin(0, 1'b1, e);
        rd(3'd2, s);
        check("R6 status bit7 after ch0 capture", {8'h0, s}, 16'h0080);
        read_cap(0, v);
        check("R3 ch0 capture value", v, e);
        rd(3'd2, s);
        check("R6 flag cleared by status then low read", {8'h0, s}, 16'h0);
        pin(0, 1'b0, e);
        rd(3'd2, s);
        check("R2 falling edge ignored on rising channel", {8'h0, s}, 16'h0);
    endtask

    task automatic t_fall_ch1();
        logic [15:0] e, v; logic [7:0] s;
        pin(1, 1'b1, e);
        rd(3'd2, s);
        check("R2 rising edge ignored on falling channel", {8'h0, s}, 16'h0);
        read_cap(1, v);
        check("R2 ch1 register untouched", v, 16'h0);
        repeat (3) @(negedge clk);
        pin(1, 1'b0, e);
        rd(3'd2, s);
        check("R2 ch1 falling capture flag bit4", {8'h0, s}, 16'h0010);
        read_cap(1, v);
        check("R3 ch1 capture value", v, e);
    endtask

    task automatic t_irq();
        logic [15:0] e; logic [7:0] s;
        pin(0, 1'b1, e);
        check("R5 pending with enables off", {15'h0, irq}, 16'h0);
        wr(3'd0, 8'h03);
        check("R5 no irq without global enable", {15'h0, irq}, 16'h0);
        wr(3'd0, 8'h07);
        check("R5 irq with both enables", {15'h0, irq}, 16'h1);
        rd(3'd2, s);
        rd(3'd5, s);
        check("R5 irq drops after clear", {15'h0, irq}, 16'h0);
        wr(3'd0, 8'h01);
        pin(0, 1'b0, e);
    endtask

    task automatic t_clear_seq();
        logic [15:0] e; logic [7:0] s;
        rd(3'd2, s);                   // read while clear: must not arm
        pin(0, 1'b1, e);
        rd(3'd5, s);
        rd(3'd2, s);
        check("R6 low read without armed status keeps flag", {8'h0, s}, 16'h0080);
        wr(3'd5, 8'h5A);               // low-byte write completes the clear
        rd(3'd2, s);
        check("R6 low write after status read clears", {8'h0, s}, 16'h0);
        pin(0, 1'b0, e);
    endtask

    task automatic t_lock();
        logic [15:0] a, b, v; logic [7:0] h, l, s;
        pin(0, 1'b1, a);
        rd(3'd4, h);
        check("R7 high byte", {8'h0, h}, {8'h0, a[15:8]});
        pin(0, 1'b0, b);
        repeat (5) @(negedge clk);
        pin(0, 1'b1, b);               // arrives while locked
        rd(3'd2, s);
        check("R7 flag set while locked", {8'h0, s}, 16'h0080);
        rd(3'd5, l);
        check("R7 locked pair consistent", {h, l}, a);
        read_cap(0, v);
        check("R7 locked edge discarded", v, a);
        pin(0, 1'b0, b);
        pin(0, 1'b1, b);
        read_cap(0, v);
        check("R7 capture resumes after unlock", v, b);
    endtask

    task automatic t_ratios();
        logic [15:0] a, b, v; logic [7:0] s;
        wr(3'd1, 8'h00);               // divide by 4
        pin(0, 1'b0, a);
        pin(0, 1'b1, a);
        repeat (37) @(negedge clk);
        pin(0, 1'b0, b);
        pin(0, 1'b1, b);
        read_cap(0, v);
        check("R8 latest capture overwrites", v, b);
        check("R4 divide by 4 timestamp", v, b);
        wr(3'd1, 8'h04);               // divide by 8
        repeat (29) @(negedge clk);
        pin(0, 1'b0, a);
        pin(0, 1'b1, a);
        read_cap(0, v);
        check("R4 divide by 8 timestamp", v, a);
        wr(3'd1, 8'h06);               // code 11, also divide by 8
        repeat (51) @(negedge clk);
        pin(0, 1'b0, a);
        pin(0, 1'b1, a);
        read_cap(0, v);
        check("R4 code 11 timestamp", v, a);
        rd(3'd1, s);
        check("R4 clock field readback", {8'h0, s}, 16'h0006);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rise_ch0();
        t_fall_ch1();
        t_irq();
        t_clear_seq();
        t_lock();
        t_ratios();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule